// File: doc/BRIEF.md
# Dual-Mode Watchdog / Periodic Alarm Countdown

This block is a down counter with a software-written seed of three bytes. In periodic-alarm mode it counts seconds. When it expires it raises a flag and starts again from the seed. In watchdog mode it counts at 4096 Hz and stops at zero. Any access to a seed byte, or a rising edge on an external strobe, restarts it from the seed. Two enables, one for each rate, arrive from a prescaler outside the block. A host reaches the seed bytes and the alarm flag through simple single-cycle strobes.

There is one active-low interrupt request. In alarm mode it is a level that follows the flag. In watchdog mode it is a fixed-length pulse of `PULSE_TICKS` fast ticks, which nothing can shorten. When the pulse ends, hardware clears the flag. While counting is disabled, or the seed is all zero, the three bytes are plain read/write storage.

Top module: `dual_countdown`

## Requirements
- R1: After reset, count_o is 0, af_o is 0, irq_n_o is 1, and every seed byte reads back 0.
- R2: While cnt_en_i is 0 or all seed bits are 0, ticks leave count_o unchanged. Byte index 0 holds seed bits 7:0, index 1 holds bits 15:8 and index 2 holds bits 23:16. acc_rdata_o shows the byte selected by acc_idx_i.
- R3: A write (acc_wr_i) stores acc_wdata_i in the selected byte. In the next cycle count_o equals the whole updated seed.
- R4: With wd_mode_i = 0 and counting enabled, each tick_slow_i lowers count_o by one. A tick that finds count_o at 1 (or 0) sets af_o and reloads the seed.
- R5: In alarm mode, irq_n_o is 0 exactly while af_o, int_mode_i and irq_en_i are all 1.
- R6: With wd_mode_i = 1 and counting enabled, each tick_fast_i lowers count_o by one. A tick at 1 sets af_o and leaves count_o at 0, and count_o stays there while no reload occurs.
- R7: In watchdog mode, a read of any byte (acc_rd_i) reloads the seed in the next cycle. So does a strobe_i rising edge, which passes two synchronizer flops and reloads on the third clock edge after the rise. A steady strobe level causes no reload.
- R8: A watchdog expiry with int_mode_i = irq_en_i = 1 drives irq_n_o low for exactly PULSE_TICKS tick_fast_i pulses. On the last of them, af_o is cleared by hardware.
- R9: During that pulse, writing 0 to the flag leaves af_o at 1, and lowering irq_en_i does not raise irq_n_o.
- R10: A seed write during the pulse loads count_o, but the count does not decrease until the pulse has ended.
- R11: flag_wr_i with flag_wdata_i = 0 clears af_o, and with flag_wdata_i = 1 has no effect. af_o is set on expiry whatever int_mode_i is. An expiry and a clear in the same cycle leave af_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow_i | input | 1 | 1 Hz enable, one cycle wide |
| tick_fast_i | input | 1 | 4096 Hz enable, one cycle wide |
| strobe_i | input | 1 | Asynchronous watchdog kick, rising edge acts |
| cnt_en_i | input | 1 | 1 = counter runs, 0 = storage only |
| wd_mode_i | input | 1 | 0 = periodic alarm, 1 = watchdog |
| int_mode_i | input | 1 | 1 = output carries the interrupt |
| irq_en_i | input | 1 | Interrupt enable |
| acc_wr_i | input | 1 | Seed byte write strobe |
| acc_rd_i | input | 1 | Seed byte read strobe |
| acc_idx_i | input | IDX_W | Seed byte index |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Selected seed byte |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write value (only 0 acts) |
| count_o | output | CNT_W | Current count |
| af_o | output | 1 | Alarm flag |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Three pairs of functions can fall in the same cycle.

- **Expiry and flag clear.** The bench lowers the count to one, then raises tick_slow_i together with a flag clear. af_o must then be 1.
- **Pulse timer and flag clear.** The bench writes 0 to the flag and lowers irq_en_i while the pulse is running. af_o must stay 1 and irq_n_o must stay 0.
- **Seed write and frozen counting.** The bench writes the seed while the pulse is running. The new value must appear in count_o but hold through the pulse-ending tick, and the count must drop only on the tick after that.

A behavioural model in the bench judges every cycle of these sequences, alongside the directed checks.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic enable;
        logic wd_mode;
        logic int_mode;
        logic irq_en;
    } dcnt_ctrl_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD_NEW,
        ACT_LOAD_SEED,
        ACT_DEC,
        ACT_EXP_STOP,
        ACT_EXP_WRAP
    } cnt_act_e;

    // Priority: host write, watchdog reload, then a tick-driven advance.
    function automatic cnt_act_e pick_action(
        input logic load_new,
        input logic load_seed,
        input logic advance,
        input logic wd,
        input logic at_zero,
        input logic at_one
    );
        if (load_new)  return ACT_LOAD_NEW;
        if (load_seed) return ACT_LOAD_SEED;
        if (!advance)  return ACT_HOLD;
        if (wd) begin
            if (at_zero) return ACT_HOLD;
            if (at_one)  return ACT_EXP_STOP;
            return ACT_DEC;
        end
        if (at_zero || at_one) return ACT_EXP_WRAP;
        return ACT_DEC;
    endfunction

endpackage

// File: rtl/dcnt_seed_store.sv
module dcnt_seed_store #(
    parameter int unsigned NBYTES = 3,
    localparam int unsigned W  = NBYTES * dcnt_pkg::BYTE_W,
    localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [IW-1:0] idx_i,
    input  logic [7:0]    wdata_i,
    output logic [W-1:0]  seed_o,
    output logic [W-1:0]  seed_next_o,
    output logic [7:0]    rdata_o
);
    logic [NBYTES-1:0][7:0] seed_q;
    logic [NBYTES-1:0][7:0] seed_n;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic hit;
        assign hit = wr_i && (idx_i == IW'(b));
        assign seed_n[b] = hit ? wdata_i : seed_q[b];
        always_ff @(posedge clk) begin
            if (rst)      seed_q[b] <= '0;
            else if (hit) seed_q[b] <= wdata_i;
        end
    end

    assign seed_o      = seed_q;
    assign seed_next_o = seed_n;

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (idx_i == IW'(b)) rdata_o = seed_q[b];
        end
    end
endmodule

// File: rtl/dcnt_sync_edge.sv
module dcnt_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dcnt_pulse_gen.sv
module dcnt_pulse_gen #(
    parameter int unsigned TICKS = 1024,
    localparam int unsigned PW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    output logic active_o,
    output logic done_o
);
    logic          act_q;
    logic [PW-1:0] cnt_q;
    logic          last;

    assign last   = (cnt_q == PW'(TICKS - 1));
    assign done_o = act_q && tick_i && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (act_q && tick_i) begin
            if (last) act_q <= 1'b0;
            else      cnt_q <= cnt_q + PW'(1);
        end
    end

    assign active_o = act_q;
endmodule

// File: rtl/dual_countdown.sv
module dual_countdown #(
    parameter int unsigned CNT_BYTES   = 3,
    parameter int unsigned PULSE_TICKS = 1024,
    localparam int unsigned CNT_W = CNT_BYTES * dcnt_pkg::BYTE_W,
    localparam int unsigned IDX_W = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_slow_i,
    input  logic             tick_fast_i,
    input  logic             strobe_i,
    input  logic             cnt_en_i,
    input  logic             wd_mode_i,
    input  logic             int_mode_i,
    input  logic             irq_en_i,
    input  logic             acc_wr_i,
    input  logic             acc_rd_i,
    input  logic [IDX_W-1:0] acc_idx_i,
    input  logic [7:0]       acc_wdata_i,
    output logic [7:0]       acc_rdata_o,
    input  logic             flag_wr_i,
    input  logic             flag_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             af_o,
    output logic             irq_n_o
);
    import dcnt_pkg::*;

    dcnt_ctrl_t       ctrl;
    logic [CNT_W-1:0] seed_q;
    logic [CNT_W-1:0] seed_next;
    logic [CNT_W-1:0] cnt_q;
    logic             strobe_rise;
    logic             pulse_active;
    logic             pulse_done;
    logic             pulse_start;
    logic             running;
    logic             tick_sel;
    logic             expire;
    logic             af_q;
    cnt_act_e         act;

    assign ctrl = '{enable: cnt_en_i, wd_mode: wd_mode_i,
                    int_mode: int_mode_i, irq_en: irq_en_i};

    dcnt_seed_store #(.NBYTES(CNT_BYTES)) u_seed (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (acc_wr_i),
        .idx_i       (acc_idx_i),
        .wdata_i     (acc_wdata_i),
        .seed_o      (seed_q),
        .seed_next_o (seed_next),
        .rdata_o     (acc_rdata_o)
    );

    dcnt_sync_edge #(.STAGES(2)) u_kick (
        .clk     (clk),
        .rst     (rst),
        .async_i (strobe_i),
        .rise_o  (strobe_rise)
    );

    dcnt_pulse_gen #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .start_i  (pulse_start),
        .tick_i   (tick_fast_i),
        .active_o (pulse_active),
        .done_o   (pulse_done)
    );

    assign running  = ctrl.enable && (|seed_q);
    assign tick_sel = ctrl.wd_mode ? tick_fast_i : tick_slow_i;

    assign act = pick_action(
        acc_wr_i,
        running && ctrl.wd_mode && (acc_rd_i || strobe_rise),
        running && !pulse_active && tick_sel,
        ctrl.wd_mode,
        cnt_q == '0,
        cnt_q == CNT_W'(1)
    );

    assign expire      = (act == ACT_EXP_STOP) || (act == ACT_EXP_WRAP);
    assign pulse_start = (act == ACT_EXP_STOP) && ctrl.int_mode && ctrl.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD_NEW:  cnt_q <= seed_next;
                ACT_LOAD_SEED: cnt_q <= seed_q;
                ACT_DEC:       cnt_q <= cnt_q - CNT_W'(1);
                ACT_EXP_STOP:  cnt_q <= '0;
                ACT_EXP_WRAP:  cnt_q <= seed_q;
                default:       cnt_q <= cnt_q;
            endcase
        end
    end

    // Flag: set wins, then the pulse end, then a software clear outside a pulse.
    always_ff @(posedge clk) begin
        if (rst)                                           af_q <= 1'b0;
        else if (expire)                                   af_q <= 1'b1;
        else if (pulse_done)                               af_q <= 1'b0;
        else if (flag_wr_i && !flag_wdata_i && !pulse_active) af_q <= 1'b0;
    end

    assign count_o = cnt_q;
    assign af_o    = af_q;
    assign irq_n_o = ~(pulse_active ||
                       (ctrl.int_mode && ctrl.irq_en && !ctrl.wd_mode && af_q));
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_wr_i,
    input logic             acc_rd_i,
    input logic [IDX_W-1:0] acc_idx_i,
    input logic [7:0]       acc_wdata_i,
    input logic             cnt_en_i,
    input logic             wd_mode_i,
    input logic             flag_wr_i,
    input logic             flag_wdata_i,
    input logic [CNT_W-1:0] count_o,
    input logic             af_o,
    input logic             irq_n_o,
    input logic             strobe_rise,
    input logic             pulse_active,
    input logic             pulse_done
);
    p_write_loads_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_wr_i && acc_idx_i == '0) |=> (count_o[7:0] == $past(acc_wdata_i)));

    p_storage_still_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en_i && !acc_wr_i) |=> $stable(count_o));

    p_wd_stops_r6: assert property (@(posedge clk) disable iff (rst)
        (wd_mode_i && count_o == '0 && !acc_wr_i && !acc_rd_i && !strobe_rise)
        |=> (count_o == '0));

    p_pulse_low_r8: assert property (@(posedge clk) disable iff (rst)
        pulse_active |-> !irq_n_o);

    p_pulse_keeps_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (pulse_active && !pulse_done) |=> af_o);

    p_flag_one_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (af_o && flag_wr_i && flag_wdata_i && !pulse_done) |=> af_o);
endmodule

bind dual_countdown dcnt_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_wr_i     (acc_wr_i),
    .acc_rd_i     (acc_rd_i),
    .acc_idx_i    (acc_idx_i),
    .acc_wdata_i  (acc_wdata_i),
    .cnt_en_i     (cnt_en_i),
    .wd_mode_i    (wd_mode_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .count_o      (count_o),
    .af_o         (af_o),
    .irq_n_o      (irq_n_o),
    .strobe_rise  (strobe_rise),
    .pulse_active (pulse_active),
    .pulse_done   (pulse_done)
);

// File: tb/dual_countdown_bench.sv
`timescale 1ns/1ps
module dual_countdown_bench;
    localparam int unsigned PT = 1024;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic tslow = 0, tfast = 0, strobe = 0, en = 0, wd = 0, intm = 0, ien = 0;
    logic acc_wr = 0, acc_rd = 0, fwr = 0, fdata = 0;
    logic [1:0]  idx = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [23:0] count;
    logic        af, irq_n;

    dual_countdown u_dual_countdown (
        .clk(clk), .rst(rst), .tick_slow_i(tslow), .tick_fast_i(tfast),
        .strobe_i(strobe), .cnt_en_i(en), .wd_mode_i(wd), .int_mode_i(intm),
        .irq_en_i(ien), .acc_wr_i(acc_wr), .acc_rd_i(acc_rd), .acc_idx_i(idx),
        .acc_wdata_i(wdata), .acc_rdata_o(rdata), .flag_wr_i(fwr),
        .flag_wdata_i(fdata), .count_o(count), .af_o(af), .irq_n_o(irq_n)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    live   = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [23:0] m_seed, m_cnt;
    bit m_af, m_pact, mt, sy, pv;
    int m_pleft;

    always @(posedge clk) begin : model
        bit rise, run, hit, startp, done, oldp;
        logic [23:0] ns;
        if (rst) begin
            m_seed = 0; m_cnt = 0; m_af = 0; m_pact = 0; m_pleft = 0;
            mt = 0; sy = 0; pv = 0;
        end else begin
            rise = sy & ~pv; pv = sy; sy = mt; mt = strobe;
            run = en && (m_seed != 0);
            oldp = m_pact; hit = 0; startp = 0; done = 0;
            if (acc_wr) begin
                ns = m_seed;
                ns[idx*8 +: 8] = wdata;
                m_seed = ns; m_cnt = ns;
            end else if (run && wd && (acc_rd || rise)) begin
                m_cnt = m_seed;
            end else if (run && !oldp) begin
                if (!wd && tslow) begin
                    if (m_cnt <= 1) begin m_cnt = m_seed; hit = 1; end
                    else m_cnt = m_cnt - 1;
                end else if (wd && tfast && m_cnt != 0) begin
                    if (m_cnt == 1) begin m_cnt = 0; hit = 1; startp = intm && ien; end
                    else m_cnt = m_cnt - 1;
                end
            end
            if (oldp && tfast) begin
                if (m_pleft == 1) begin m_pact = 0; done = 1; end
                else m_pleft = m_pleft - 1;
            end
            if (startp) begin m_pact = 1; m_pleft = PT; end
            if (hit) m_af = 1;
            else if (done) m_af = 0;
            else if (fwr && !fdata && !oldp) m_af = 0;
        end
    end

    always @(negedge clk) begin
        if (live && !rst) begin
            chk({phase, " model count"}, 32'(count), 32'(m_cnt));
            chk({phase, " model flag"}, 32'(af), 32'(m_af));
            chk({phase, " model irq"}, 32'(irq_n),
                32'(!(m_pact || (intm && ien && !wd && m_af))));
            chk({phase, " model rdata"}, 32'(rdata), 32'((m_seed >> (idx*8)) & 24'hff));
        end
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask
    task automatic wr_byte(input logic [1:0] i, input logic [7:0] d);
        acc_wr = 1; idx = i; wdata = d; cyc(); acc_wr = 0;
    endtask
    task automatic rd_byte(input logic [1:0] i);
        acc_rd = 1; idx = i; cyc(); acc_rd = 0;
    endtask
    task automatic tick_s(input int n);
        for (int k = 0; k < n; k++) begin tslow = 1; cyc(); tslow = 0; cyc(); end
    endtask
    task automatic tick_f(input int n);
        for (int k = 0; k < n; k++) begin tfast = 1; cyc(); tfast = 0; cyc(); end
    endtask
    task automatic flag(input logic d);
        fwr = 1; fdata = d; cyc(); fwr = 0; fdata = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL WATCHDOG actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        rst = 1; cyc(); cyc(); cyc(); rst = 0; cyc(); live = 1;
        // R1: reset state
        chk("R1 count", 32'(count), 0);
        chk("R1 flag", 32'(af), 0);
        chk("R1 irq", 32'(irq_n), 1);
        for (int i = 0; i < 3; i++) begin
            idx = 2'(i); cyc(); chk("R1 byte", 32'(rdata), 0);
        end

        // R2 / R3: storage mode
        phase = "R3";
        wr_byte(0, 8'h12); chk("R3 load", 32'(count), 32'h12);
        wr_byte(1, 8'h34); chk("R3 load", 32'(count), 32'h3412);
        wr_byte(2, 8'h56); chk("R3 load", 32'(count), 32'h563412);
        phase = "R2";
        idx = 1; cyc(); chk("R2 read", 32'(rdata), 32'h34);
        idx = 2; cyc(); chk("R2 read", 32'(rdata), 32'h56);
        tick_s(3); tick_f(3);
        chk("R2 storage still", 32'(count), 32'h563412);
        en = 1;
        wr_byte(0, 0); wr_byte(1, 0); wr_byte(2, 0);
        tick_s(2); tick_f(2);
        chk("R2 zero seed", 32'(count), 0);
        chk("R2 zero seed flag", 32'(af), 0);

        // R4 / R5: alarm mode
        phase = "R4"; wd = 0; intm = 1; ien = 1;
        wr_byte(0, 8'd3); chk("R4 seed", 32'(count), 3);
        tick_s(1); chk("R4 dec", 32'(count), 2);
        tick_s(1); chk("R4 dec", 32'(count), 1);
        tick_s(1); chk("R4 wrap", 32'(count), 3);
        chk("R4 flag", 32'(af), 1);
        phase = "R5";
        chk("R5 irq level", 32'(irq_n), 0);
        ien = 0; cyc(); chk("R5 irq off", 32'(irq_n), 1);
        ien = 1; cyc(); chk("R5 irq back", 32'(irq_n), 0);
        phase = "R11";
        flag(1); chk("R11 write one", 32'(af), 1);
        flag(0); chk("R11 write zero", 32'(af), 0);
        chk("R5 irq released", 32'(irq_n), 1);
        intm = 0; tick_s(3);
        chk("R11 set without int", 32'(af), 1);
        chk("R5 no irq in sq mode", 32'(irq_n), 1);
        flag(0);
        tick_s(2); chk("R4 before tie", 32'(count), 1);
        tslow = 1; fwr = 1; fdata = 0; cyc(); tslow = 0; fwr = 0;
        chk("R11 set beats clear", 32'(af), 1);
        chk("R4 wrap at tie", 32'(count), 3);
        flag(0);

        // R6 / R7: watchdog mode
        phase = "R6"; wd = 1; intm = 1; ien = 0;
        wr_byte(0, 8'd5);
        tick_f(2); chk("R6 dec", 32'(count), 3);
        phase = "R7";
        strobe = 1; cyc(); cyc(); cyc();
        chk("R7 strobe reload", 32'(count), 5);
        tick_f(2); cyc(); cyc(); cyc(); cyc();
        chk("R7 steady no reload", 32'(count), 3);
        rd_byte(0); chk("R7 read reload", 32'(count), 5);
        strobe = 0;
        phase = "R6";
        tick_f(5);
        chk("R6 expire", 32'(count), 0);
        chk("R6 flag", 32'(af), 1);
        chk("R6 no pulse", 32'(irq_n), 1);
        tick_f(3); chk("R6 stopped", 32'(count), 0);
        flag(0);

        // R8 - R10: pulse
        phase = "R8"; ien = 1;
        rd_byte(2); chk("R7 read byte2 reload", 32'(count), 5);
        tick_f(5);
        chk("R8 pulse start", 32'(irq_n), 0);
        chk("R8 flag", 32'(af), 1);
        phase = "R9";
        flag(0); chk("R9 clear ignored", 32'(af), 1);
        ien = 0; cyc(); chk("R9 irq held", 32'(irq_n), 0);
        phase = "R10";
        wr_byte(0, 8'd7); chk("R10 loaded", 32'(count), 7);
        tick_f(3); chk("R10 frozen", 32'(count), 7);
        phase = "R8";
        tick_f(PT - 4);
        chk("R8 still low", 32'(irq_n), 0);
        chk("R8 still set", 32'(af), 1);
        tick_f(1);
        chk("R8 pulse end", 32'(irq_n), 1);
        chk("R8 hw clear", 32'(af), 0);
        chk("R10 frozen at end", 32'(count), 7);
        phase = "R10";
        tick_f(1); chk("R10 resumes", 32'(count), 6);

        live = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule